// File: doc/BRIEF.md
# I2C Boot-Image EEPROM Emulator

This block presents itself on an I2C bus as a small serial EEPROM, so that a microcontroller that boots from an external EEPROM can load its firmware from the chip. The bytes it serves live in an internal RAM. The local host processor fills that RAM through a plain write port before the microcontroller is released from reset. After that, the I2C side only reads the RAM.

The target supports the two read styles a boot loader uses. In a current-address read, the master addresses the device for reading and receives bytes from the internal pointer onward. In a random read, the master first writes a two-byte word address, most significant byte first. It then issues a repeated START and reads from that address. The pointer advances after every byte sent and wraps at the top of the address space. Write transactions from the I2C side only set the pointer. The RAM is never programmed from the bus.

The inputs SCL and SDA are synchronised to the system clock. SDA is open-drain: the block either pulls it low or releases it. The `ADDR_W` parameter sizes the image. A value of 14 covers a 16 KB image. The default keeps the RAM small.

Top module: `i2c_eeprom_emu`

## Requirements
- R1: After reset the block releases SDA (`sda_pull` = 0) and the read pointer is 0, so a first current-address read returns RAM byte 0.
- R2: The block acknowledges (pulls SDA low during the ninth clock) a control byte whose upper seven bits equal `DEV_ADDR` (default 0x50). It ignores any other control byte, leaving SDA released until the next START.
- R3: A current-address read returns RAM bytes starting at the pointer, and the pointer increments by one after every byte sent, across transactions.
- R4: A write transaction acknowledges two address bytes, most significant first, and loads the pointer. A repeated-START read then returns data from that address onward.
- R5: Data bytes the master writes after the two address bytes are not acknowledged and not stored. A later read of that location returns the RAM content unchanged.
- R6: A write on the host port (`host_wr_en`, `host_wr_addr`, `host_wr_data`) stores the byte in the RAM, and later I2C reads return it.
- R7: A NACK from the master after a read byte ends the transfer. SDA stays released for any further clocks until the next START or STOP.
- R8: The pointer wraps from 2^ADDR_W-1 to 0. Address bits at or above ADDR_W in the two address bytes are ignored.
- R9: The block changes its SDA drive only while SCL is low, and never drives SDA high.
- R10: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. A repeated START restarts control-byte reception in any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr_en | input | 1 | Host RAM write strobe |
| host_wr_addr | input | ADDR_W | Host RAM write address |
| host_wr_data | input | 8 | Host RAM write byte |
| scl_in | input | 1 | SCL line as seen at the pad |
| sda_in | input | 1 | SDA line as seen at the pad |
| sda_pull | output | 1 | 1 = pull SDA low, 0 = release |

## Verification
A wrong pointer shows up at the pins as a wrong byte in the very next read, so every read byte is compared against a behavioural model of the RAM and pointer. A mis-stepped bit counter or state shows up as an acknowledge in the wrong clock, a missing acknowledge, or SDA held low after a NACK. These are seen at the ninth clock of the affected byte. A drive change while SCL is high would corrupt the line within one bit time. A per-clock watch on `sda_pull` against `scl_in` catches it.

// File: rtl/i2c_emu_pkg.sv
// Shared types for the I2C EEPROM emulator.
// Assumes: one byte is eight bits plus one acknowledge clock.
package i2c_emu_pkg;

    localparam int BYTE_BITS = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CTRL,
        ST_CTRL_ACK,
        ST_ADRH,
        ST_ADRH_ACK,
        ST_ADRL,
        ST_ADRL_ACK,
        ST_DISCARD,
        ST_SEND,
        ST_SEND_ACK
    } tgt_state_t;

endpackage

// File: rtl/i2c_line_sync.sv
// Synchronises SCL/SDA into the clock domain and flags bus events.
// Assumes: the system clock is many times faster than SCL, STAGES >= 2.
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);

    logic [STAGES-1:0] scl_chain;
    logic [STAGES-1:0] sda_chain;
    logic              scl_prev;
    logic              sda_prev;

    // Synchroniser chains and one-cycle history; lines idle high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_chain <= '1;
            sda_chain <= '1;
            scl_prev  <= 1'b1;
            sda_prev  <= 1'b1;
        end else begin
            scl_chain <= {scl_chain[STAGES-2:0], scl_raw};
            sda_chain <= {sda_chain[STAGES-2:0], sda_raw};
            scl_prev  <= scl_chain[STAGES-1];
            sda_prev  <= sda_chain[STAGES-1];
        end
    end

    // Edge and bus-condition decode from current and previous samples.
    always_comb begin
        scl_lvl   = scl_chain[STAGES-1];
        sda_lvl   = sda_chain[STAGES-1];
        scl_rise  = scl_lvl & ~scl_prev;
        scl_fall  = ~scl_lvl & scl_prev;
        start_evt = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
        stop_evt  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
    end

endmodule

// File: rtl/emu_byte_ram.sv
// Byte RAM: host write port, registered read port for the I2C side.
// Assumes: read address stays stable for at least two clocks before use.
module emu_byte_ram #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem [DEPTH];

    // Host write and registered read.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
        rd_data <= mem[rd_addr];
    end

endmodule

// File: rtl/i2c_target_fsm.sv
// Bit engine and transaction sequencer of the EEPROM-style target.
// Receives control/address bytes, loads the pointer, shifts out read data,
// and drives SDA low only while SCL is low.
// Assumes: synchronised inputs from i2c_line_sync; rd_data valid one clock
// after ptr changes.
module i2c_target_fsm
    import i2c_emu_pkg::*;
#(
    parameter int         ADDR_W   = 11,
    parameter logic [6:0] DEV_ADDR = 7'h50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_lvl,
    input  logic              sda_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_evt,
    input  logic              stop_evt,
    input  logic [7:0]        rd_data,
    output logic [ADDR_W-1:0] ptr,
    output logic              sda_pull
);

    localparam logic [3:0] LAST_BIT = 4'(BYTE_BITS);

    tgt_state_t  state;
    logic [7:0]  shreg;
    logic [3:0]  bitcnt;
    logic        rd_req;
    logic        mst_ack;
    logic [7:0]  adr_hi;
    logic [15:0] full_adr;
    logic        ptr_inc;
    logic        rx_state;

    // Helper decodes used by the sequencer.
    always_comb begin
        full_adr = {adr_hi, shreg};
        rx_state = (state == ST_CTRL) || (state == ST_ADRH) || (state == ST_ADRL);
        ptr_inc  = (state == ST_SEND) && scl_fall && (bitcnt == LAST_BIT)
                   && !start_evt && !stop_evt;
    end

    // Transaction sequencer, shift register and SDA drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            shreg    <= '0;
            bitcnt   <= '0;
            rd_req   <= 1'b0;
            mst_ack  <= 1'b0;
            adr_hi   <= '0;
            ptr      <= '0;
            sda_pull <= 1'b0;
        end else if (start_evt) begin
            state    <= ST_CTRL;
            bitcnt   <= '0;
            sda_pull <= 1'b0;
        end else if (stop_evt) begin
            state    <= ST_IDLE;
            sda_pull <= 1'b0;
        end else if (rx_state) begin
            if (scl_rise) begin
                shreg  <= {shreg[6:0], sda_lvl};
                bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == LAST_BIT) begin
                bitcnt <= '0;
                if (state == ST_CTRL) begin
                    if (shreg[7:1] == DEV_ADDR) begin
                        rd_req   <= shreg[0];
                        sda_pull <= 1'b1;
                        state    <= ST_CTRL_ACK;
                    end else begin
                        state <= ST_IDLE;
                    end
                end else if (state == ST_ADRH) begin
                    adr_hi   <= shreg;
                    sda_pull <= 1'b1;
                    state    <= ST_ADRH_ACK;
                end else begin
                    ptr      <= full_adr[ADDR_W-1:0];
                    sda_pull <= 1'b1;
                    state    <= ST_ADRL_ACK;
                end
            end
        end else begin
            case (state)
                ST_CTRL_ACK: begin
                    if (scl_fall) begin
                        if (rd_req) begin
                            shreg    <= rd_data;
                            sda_pull <= ~rd_data[7];
                            bitcnt   <= '0;
                            state    <= ST_SEND;
                        end else begin
                            sda_pull <= 1'b0;
                            state    <= ST_ADRH;
                        end
                    end
                end
                ST_ADRH_ACK: begin
                    if (scl_fall) begin
                        sda_pull <= 1'b0;
                        state    <= ST_ADRL;
                    end
                end
                ST_ADRL_ACK: begin
                    if (scl_fall) begin
                        sda_pull <= 1'b0;
                        state    <= ST_DISCARD;
                    end
                end
                ST_SEND: begin
                    if (scl_rise) begin
                        bitcnt <= bitcnt + 4'd1;
                    end else if (scl_fall) begin
                        if (bitcnt == LAST_BIT) begin
                            sda_pull <= 1'b0;
                            ptr      <= ptr + 1'b1;
                            state    <= ST_SEND_ACK;
                        end else begin
                            shreg    <= {shreg[6:0], 1'b0};
                            sda_pull <= ~shreg[6];
                        end
                    end
                end
                ST_SEND_ACK: begin
                    if (scl_rise) begin
                        mst_ack <= ~sda_lvl;
                    end else if (scl_fall) begin
                        if (mst_ack) begin
                            shreg    <= rd_data;
                            sda_pull <= ~rd_data[7];
                            bitcnt   <= '0;
                            state    <= ST_SEND;
                        end else begin
                            sda_pull <= 1'b0;
                            state    <= ST_IDLE;
                        end
                    end
                end
                default: begin
                    sda_pull <= 1'b0;
                end
            endcase
        end
    end

    // R9: the drive only changes while the synchronised SCL is low.
    assert_drive_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull) |-> !scl_lvl);

    // R7: a STOP leaves SDA released.
    assert_release_after_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> !sda_pull);

    // R7: no drive while waiting for the next START or STOP.
    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE || state == ST_DISCARD) |-> !sda_pull);

    // R8: the pointer wraps to zero from its top value.
    assert_ptr_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_inc && ptr == {ADDR_W{1'b1}}) |=> (ptr == '0));

    // R10: a START always restarts control-byte reception.
    assert_start_restarts_R10: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> (state == ST_CTRL && bitcnt == 4'd0));

endmodule

// File: rtl/i2c_eeprom_emu.sv
// Top level: I2C target emulating a serial boot EEPROM backed by host RAM.
// Assumes: clk is at least ~10x the SCL rate; sda_pull drives an open-drain pad.
module i2c_eeprom_emu #(
    parameter int         ADDR_W      = 11,
    parameter logic [6:0] DEV_ADDR    = 7'h50,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr_en,
    input  logic [ADDR_W-1:0] host_wr_addr,
    input  logic [7:0]        host_wr_data,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_pull
);

    logic              scl_lvl, sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;
    logic [ADDR_W-1:0] rd_ptr;
    logic [7:0]        rd_byte;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_raw   (scl_in),
        .sda_raw   (sda_in),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt)
    );

    emu_byte_ram #(.ADDR_W(ADDR_W)) u_ram (
        .clk     (clk),
        .wr_en   (host_wr_en),
        .wr_addr (host_wr_addr),
        .wr_data (host_wr_data),
        .rd_addr (rd_ptr),
        .rd_data (rd_byte)
    );

    i2c_target_fsm #(.ADDR_W(ADDR_W), .DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt),
        .rd_data   (rd_byte),
        .ptr       (rd_ptr),
        .sda_pull  (sda_pull)
    );

endmodule

// File: tb/i2c_eeprom_emu_tb.sv
module i2c_eeprom_emu_tb;

    localparam int CLK_PERIOD = 10;
    localparam int AW         = 11;
    localparam int DEPTH      = 1 << AW;
    localparam int H          = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_wr_en = 1'b0;
    logic [AW-1:0] host_wr_addr = '0;
    logic [7:0]    host_wr_data = '0;
    logic          scl_m = 1'b1;
    logic          sda_m = 1'b1;
    logic          sda_pull;
    logic          sda_bus;

    int n_chk = 0;
    int n_fail = 0;
    int r9_viol = 0;
    int scl_hi_run = 0;
    logic prev_pull = 1'b0;

    byte unsigned model_mem [DEPTH];
    int           model_ptr = 0;

    assign sda_bus = sda_m & ~sda_pull;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_eeprom_emu u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_wr_en   (host_wr_en),
        .host_wr_addr (host_wr_addr),
        .host_wr_data (host_wr_data),
        .scl_in       (scl_m),
        .sda_in       (sda_bus),
        .sda_pull     (sda_pull)
    );

    // Per-clock watch: drive must not change after SCL has been high a while (R9).
    always @(posedge clk) begin
        if (rst_n) begin
            if (scl_hi_run >= 4 && sda_pull !== prev_pull) r9_viol++;
            if (sda_pull === 1'bx) r9_viol++;
        end
        scl_hi_run = scl_m ? scl_hi_run + 1 : 0;
        prev_pull = sda_pull;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic host_wr(input int a, input byte unsigned d);
        @(negedge clk);
        host_wr_en = 1'b1;
        host_wr_addr = AW'(a);
        host_wr_data = d;
        @(negedge clk);
        host_wr_en = 1'b0;
        model_mem[a] = d;
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; scl_m = 1'b1; wait_clks(H);
        sda_m = 1'b0; wait_clks(H);
        scl_m = 1'b0; wait_clks(H);
    endtask

    task automatic i2c_rstart();
        sda_m = 1'b1; wait_clks(H);
        scl_m = 1'b1; wait_clks(H);
        sda_m = 1'b0; wait_clks(H);
        scl_m = 1'b0; wait_clks(H);
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; wait_clks(H);
        scl_m = 1'b1; wait_clks(H);
        sda_m = 1'b1; wait_clks(H);
    endtask

    task automatic i2c_wbyte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wait_clks(H);
            scl_m = 1'b1; wait_clks(H);
            scl_m = 1'b0; wait_clks(H);
        end
        sda_m = 1'b1; wait_clks(H);
        scl_m = 1'b1; wait_clks(H/2);
        acked = (sda_bus == 1'b0);
        wait_clks(H/2);
        scl_m = 1'b0; wait_clks(H);
    endtask

    task automatic i2c_rbyte(input bit give_ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; wait_clks(H);
            scl_m = 1'b1; wait_clks(H/2);
            b[i] = sda_bus;
            wait_clks(H/2);
            scl_m = 1'b0; wait_clks(H);
        end
        sda_m = give_ack ? 1'b0 : 1'b1; wait_clks(H);
        scl_m = 1'b1; wait_clks(H);
        scl_m = 1'b0; wait_clks(H);
        sda_m = 1'b1;
    endtask

    // Read n bytes, acking all but the last, comparing against the model.
    task automatic read_seq(input int n, input string tag);
        logic [7:0] got;
        for (int k = 0; k < n; k++) begin
            i2c_rbyte(k != n - 1, got);
            chk(got == model_mem[model_ptr], tag, got, model_mem[model_ptr]);
            model_ptr = (model_ptr + 1) % DEPTH;
        end
    endtask

    // Random-read address setup: control write, two address bytes, repeated START, control read.
    task automatic set_addr(input logic [7:0] hi, input logic [7:0] lo, input string tag);
        bit a;
        i2c_start();
        i2c_wbyte(8'hA0, a); chk(a, {tag, " ctrl-wr ack"}, a, 1);
        i2c_wbyte(hi, a);    chk(a, {tag, " addr-hi ack"}, a, 1);
        i2c_wbyte(lo, a);    chk(a, {tag, " addr-lo ack"}, a, 1);
        model_ptr = {hi, lo} % DEPTH;
        i2c_rstart();
        i2c_wbyte(8'hA1, a); chk(a, {tag, " ctrl-rd ack"}, a, 1);
    endtask

    initial begin
        repeat (300000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        bit a;
        logic [7:0] got;

        wait_clks(5);
        rst_n = 1'b1;
        wait_clks(3);
        // R1: released after reset
        chk(sda_pull == 1'b0, "R1 reset release", sda_pull, 0);

        // R6: host fills the RAM
        for (int i = 0; i < DEPTH; i++) host_wr(i, byte'((i * 7 + 3) ^ (i >> 8)));

        // R1/R3: current-address read from pointer 0
        i2c_start();
        i2c_wbyte(8'hA1, a); chk(a, "R2 ctrl-rd ack", a, 1);
        read_seq(4, "R3 first current read (R1 ptr 0)");
        i2c_stop();

        // R3: the pointer persists across transactions
        i2c_start();
        i2c_wbyte(8'hA1, a); chk(a, "R2 ack second", a, 1);
        read_seq(2, "R3 continue read");
        i2c_stop();

        // R4/R10: random read via repeated START
        set_addr(8'h01, 8'h23, "R4");
        read_seq(3, "R4 random read");
        i2c_stop();
        i2c_start();
        i2c_wbyte(8'hA1, a);
        read_seq(2, "R3 after random");
        i2c_stop();

        // R2: another address gets no ACK and no drive
        i2c_start();
        i2c_wbyte(8'hA3, a); chk(!a, "R2 foreign addr nack", a, 0);
        i2c_rbyte(1'b0, got); chk(got == 8'hFF, "R2 no drive after foreign", got, 8'hFF);
        i2c_stop();

        // R5: written data is neither acked nor stored
        i2c_start();
        i2c_wbyte(8'hA0, a); chk(a, "R5 ctrl ack", a, 1);
        i2c_wbyte(8'h00, a); chk(a, "R5 hi ack", a, 1);
        i2c_wbyte(8'h10, a); chk(a, "R5 lo ack", a, 1);
        i2c_wbyte(~model_mem[16], a); chk(!a, "R5 data nack", a, 0);
        i2c_stop();
        set_addr(8'h00, 8'h10, "R5");
        read_seq(1, "R5 data not stored");
        i2c_stop();

        // R8: wrap and ignored high address bits (0xFFFE -> 0x7FE)
        set_addr(8'hFF, 8'hFE, "R8");
        read_seq(4, "R8 wrap");
        i2c_stop();

        // R7: after master NACK, further clocks see a released line
        set_addr(8'h02, 8'h00, "R7");
        read_seq(1, "R7 byte before nack");
        i2c_rbyte(1'b1, got); chk(got == 8'hFF, "R7 released after nack", got, 8'hFF);
        i2c_stop();

        // R6: host update visible to the next read
        host_wr(5, 8'h5A);
        set_addr(8'h00, 8'h05, "R6");
        read_seq(1, "R6 host update");
        i2c_stop();

        // R10: repeated START mid-read restarts control reception
        set_addr(8'h00, 8'h40, "R10");
        i2c_rbyte(1'b1, got);
        i2c_rstart();
        i2c_wbyte(8'hA1, a); chk(a, "R10 ack after restart", a, 1);
        model_ptr = 8'h41;
        read_seq(1, "R10 read after restart");
        i2c_stop();

        wait_clks(4);
        chk(r9_viol == 0, "R9 drive change while SCL high", r9_viol, 0);
        chk(sda_pull == 1'b0, "R7 idle release at end", sda_pull, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule